// File: doc/BRIEF.md
# Addressable Multidrop JTAG Bridge Controller

This block is the backplane-facing side of a test bridge that shares one serial test bus with many identical peers, one per slot. After reset every bridge waits to be addressed, and none of them drives the shared TDO line. The test host shifts an 8-bit instruction into all bridges at once. A bridge whose hardwired slot address matches the instruction becomes selected. The broadcast code selects every bridge at once, so that update operations land at the same moment on all boards.

A selected bridge reads later instruction scans as commands. BYPASS gives a one-bit data path. MODESEL points the next data scans at a mode register, which steers the on-board local chains. UNPARK and PARKPAUSE are passed on to the local-port logic. GOTOWAIT drops the bridge back into the waiting condition. An empty slot leaves TDO undriven, so the bus pull-up returns all ones. A sweep over the address range therefore shows which slots are populated.

Top module: `jbr_bridge`

## Requirements
- R1: In Capture-IR the 8-bit instruction register loads the slot address in bits 7:2 and binary 01 in bits 1:0. A bridge selected by its own address shifts this value out on TDO, least significant bit first.
- R2: While unselected, the bridge keeps `tdo_oe_o` low in every state, so the pulled-up bus reads all ones during IR and DR scans.
- R3: An Update-IR in the waiting condition with instruction value {2'b00, slot address} selects the bridge: `selected_o` is 1 and `bcast_o` is 0.
- R4: An Update-IR in the waiting condition with value 8'hC0 selects the bridge in broadcast mode (`selected_o`=1, `bcast_o`=1). In this mode `tdo_oe_o` stays low, even during shifts.
- R5: Any other value at Update-IR in the waiting condition leaves the bridge unselected.
- R6: When selected, Update-IR decodes opcodes onto `cmd_o`: 8'hFF gives BYPASS (0), 8'h8E gives MODESEL (1), 8'hE2 gives UNPARK (2) and 8'hE3 gives PARKPAUSE (3). Every undefined opcode gives BYPASS (0).
- R7: With any command other than MODESEL, the data register is a single bypass bit. It captures 0, and TDI reappears on TDO one shift later.
- R8: Under MODESEL, a DR scan captures the current mode value, shifts MODE_W bits LSB first, and loads the shifted value into `mode_o` at Update-DR. `mode_o` changes at no other time, except on reset.
- R9: Opcode 8'hC3 (GOTOWAIT) deselects the bridge, in own-address or broadcast mode. It sets `cmd_o` to BYPASS and leaves `mode_o` unchanged.
- R10: `trst_n_i` low, or five TCK rising edges with TMS high, returns the bridge to the waiting condition with `cmd_o`=BYPASS and `mode_o`=8'h01, which routes only local port 1.
- R11: TDO changes only on TCK falling edges. `tdo_oe_o` is high only in Shift-IR or Shift-DR while the bridge is selected by its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Backplane test clock |
| tms_i | input | 1 | Backplane mode select |
| tdi_i | input | 1 | Backplane serial data in |
| trst_n_i | input | 1 | Backplane test reset, active low, asynchronous |
| slot_addr_i | input | 6 | Static slot address pins |
| tdo_o | output | 1 | Serial data out, valid when enabled |
| tdo_oe_o | output | 1 | Output enable for the shared TDO driver |
| tap_state_o | output | 4 | Current TAP state, standard 4-bit state codes |
| selected_o | output | 1 | Bridge selected (own address or broadcast) |
| bcast_o | output | 1 | Selection came through the broadcast code |
| cmd_o | output | 3 | Active command for the local-port logic |
| mode_o | output | MODE_W | Mode register contents |

## Verification
Two functions can act in one cycle: the asynchronous test reset and the mode-register write at Update-DR. The bench provokes this by shifting a new mode value under MODESEL. It then pulls `trst_n_i` low in the same half-cycle that it raises TMS to step from Exit1-DR into Update-DR. The reset must win: after that edge the mode must read 8'h01, not the shifted value, and the bridge must be unselected. A second pairing is the TDO bit change and the shift edge. The bench samples TDO just after a rising edge and again after the falling edge, and checks that the bit moves only on the falling edge.

// File: rtl/jbr_pkg.sv
package jbr_pkg;

  localparam int ADDR_W = 6;
  localparam int IR_W   = ADDR_W + 2;

  typedef enum logic [3:0] {
    ST_EXIT2_DR   = 4'h0,
    ST_EXIT1_DR   = 4'h1,
    ST_SHIFT_DR   = 4'h2,
    ST_PAUSE_DR   = 4'h3,
    ST_SELECT_IR  = 4'h4,
    ST_UPDATE_DR  = 4'h5,
    ST_CAPTURE_DR = 4'h6,
    ST_SELECT_DR  = 4'h7,
    ST_EXIT2_IR   = 4'h8,
    ST_EXIT1_IR   = 4'h9,
    ST_SHIFT_IR   = 4'hA,
    ST_PAUSE_IR   = 4'hB,
    ST_IDLE       = 4'hC,
    ST_UPDATE_IR  = 4'hD,
    ST_CAPTURE_IR = 4'hE,
    ST_RESET      = 4'hF
  } tap_st_e;

  typedef enum logic [2:0] {
    CMD_BYPASS    = 3'd0,
    CMD_MODESEL   = 3'd1,
    CMD_UNPARK    = 3'd2,
    CMD_PARKPAUSE = 3'd3
  } cmd_e;

  localparam logic [IR_W-1:0] OP_BYPASS    = 8'hFF;
  localparam logic [IR_W-1:0] OP_MODESEL   = 8'h8E;
  localparam logic [IR_W-1:0] OP_UNPARK    = 8'hE2;
  localparam logic [IR_W-1:0] OP_PARKPAUSE = 8'hE3;
  localparam logic [IR_W-1:0] OP_GOTOWAIT  = 8'hC3;
  localparam logic [IR_W-1:0] BCAST_CODE   = 8'hC0;

  function automatic cmd_e decode_op(logic [IR_W-1:0] op);
    cmd_e c;
    case (op)
      OP_MODESEL:   c = CMD_MODESEL;
      OP_UNPARK:    c = CMD_UNPARK;
      OP_PARKPAUSE: c = CMD_PARKPAUSE;
      default:      c = CMD_BYPASS;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/jbr_tap_ctrl.sv
module jbr_tap_ctrl
  import jbr_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_e state
);

  tap_st_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_RESET:      state_d = tms ? ST_RESET     : ST_IDLE;
      ST_IDLE:       state_d = tms ? ST_SELECT_DR : ST_IDLE;
      ST_SELECT_DR:  state_d = tms ? ST_SELECT_IR : ST_CAPTURE_DR;
      ST_CAPTURE_DR: state_d = tms ? ST_EXIT1_DR  : ST_SHIFT_DR;
      ST_SHIFT_DR:   state_d = tms ? ST_EXIT1_DR  : ST_SHIFT_DR;
      ST_EXIT1_DR:   state_d = tms ? ST_UPDATE_DR : ST_PAUSE_DR;
      ST_PAUSE_DR:   state_d = tms ? ST_EXIT2_DR  : ST_PAUSE_DR;
      ST_EXIT2_DR:   state_d = tms ? ST_UPDATE_DR : ST_SHIFT_DR;
      ST_UPDATE_DR:  state_d = tms ? ST_SELECT_DR : ST_IDLE;
      ST_SELECT_IR:  state_d = tms ? ST_RESET     : ST_CAPTURE_IR;
      ST_CAPTURE_IR: state_d = tms ? ST_EXIT1_IR  : ST_SHIFT_IR;
      ST_SHIFT_IR:   state_d = tms ? ST_EXIT1_IR  : ST_SHIFT_IR;
      ST_EXIT1_IR:   state_d = tms ? ST_UPDATE_IR : ST_PAUSE_IR;
      ST_PAUSE_IR:   state_d = tms ? ST_EXIT2_IR  : ST_PAUSE_IR;
      ST_EXIT2_IR:   state_d = tms ? ST_UPDATE_IR : ST_SHIFT_IR;
      ST_UPDATE_IR:  state_d = tms ? ST_SELECT_DR : ST_IDLE;
      default:       state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end

  // R10: five TMS-high edges always end in reset
  a_r10_tms_five_ones: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == ST_RESET));

endmodule

// File: rtl/jbr_ir_select.sv
module jbr_ir_select
  import jbr_pkg::*;
(
  input  logic              tck,
  input  logic              rst_n,
  input  tap_st_e           state,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              ir_lsb,
  output logic              sel_own,
  output logic              sel_bcast,
  output cmd_e              cmd
);

  logic [IR_W-1:0] ir_q, ir_d;
  logic            own_d, bc_d;
  cmd_e            cmd_d;
  logic            waiting;

  assign waiting = !sel_own && !sel_bcast;
  assign ir_lsb  = ir_q[0];

  always_comb begin
    ir_d  = ir_q;
    own_d = sel_own;
    bc_d  = sel_bcast;
    cmd_d = cmd;
    case (state)
      ST_CAPTURE_IR: ir_d = {slot_addr, 2'b01};
      ST_SHIFT_IR:   ir_d = {tdi, ir_q[IR_W-1:1]};
      ST_UPDATE_IR: begin
        if (waiting) begin
          if (ir_q == {2'b00, slot_addr}) own_d = 1'b1;
          else if (ir_q == BCAST_CODE)    bc_d  = 1'b1;
        end else if (ir_q == OP_GOTOWAIT) begin
          own_d = 1'b0;
          bc_d  = 1'b0;
          cmd_d = CMD_BYPASS;
        end else begin
          cmd_d = decode_op(ir_q);
        end
      end
      ST_RESET: begin
        own_d = 1'b0;
        bc_d  = 1'b0;
        cmd_d = CMD_BYPASS;
      end
      default: ;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_q      <= {IR_W{1'b0}};
      sel_own   <= 1'b0;
      sel_bcast <= 1'b0;
      cmd       <= CMD_BYPASS;
    end else begin
      ir_q      <= ir_d;
      sel_own   <= own_d;
      sel_bcast <= bc_d;
      cmd       <= cmd_d;
    end
  end

  // R3: own-address and broadcast selection never coexist
  a_r3_sel_exclusive: assert property (@(posedge tck) disable iff (!rst_n)
    !(sel_own && sel_bcast));

  // R3: matching address in the waiting condition selects at Update-IR
  a_r3_own_select: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPDATE_IR && !sel_own && !sel_bcast && ir_q == {2'b00, slot_addr})
      |=> (sel_own && !sel_bcast));

  // R9: GOTOWAIT from a selected condition returns to waiting
  a_r9_gotowait_leaves: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPDATE_IR && (sel_own || sel_bcast) && ir_q == OP_GOTOWAIT)
      |=> (!sel_own && !sel_bcast && cmd == CMD_BYPASS));

  // R6: an unselected bridge always presents BYPASS
  a_r6_wait_is_bypass: assert property (@(posedge tck) disable iff (!rst_n)
    (!sel_own && !sel_bcast) |-> (cmd == CMD_BYPASS));

endmodule

// File: rtl/jbr_dr_path.sv
module jbr_dr_path
  import jbr_pkg::*;
#(
  parameter int              MODE_W   = 8,
  parameter logic [MODE_W-1:0] MODE_RST = 1
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_st_e           state,
  input  logic              tdi,
  input  cmd_e              cmd,
  output logic              dr_lsb,
  output logic [MODE_W-1:0] mode
);

  logic              byp_q, byp_d;
  logic [MODE_W-1:0] msr_q, msr_d;
  logic [MODE_W-1:0] mode_d;
  logic              use_mode;

  assign use_mode = (cmd == CMD_MODESEL);
  assign dr_lsb   = use_mode ? msr_q[0] : byp_q;

  always_comb begin
    byp_d  = byp_q;
    msr_d  = msr_q;
    mode_d = mode;
    case (state)
      ST_CAPTURE_DR: begin
        byp_d = 1'b0;
        if (use_mode) msr_d = mode;
      end
      ST_SHIFT_DR: begin
        byp_d = tdi;
        if (use_mode) msr_d = {tdi, msr_q[MODE_W-1:1]};
      end
      ST_UPDATE_DR: if (use_mode) mode_d = msr_q;
      ST_RESET:     mode_d = MODE_RST;
      default: ;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      msr_q <= {MODE_W{1'b0}};
      mode  <= MODE_RST;
    end else begin
      byp_q <= byp_d;
      msr_q <= msr_d;
      mode  <= mode_d;
    end
  end

  // R8: the mode register moves only at Update-DR or in reset
  a_r8_mode_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPDATE_DR && state != ST_RESET) |=> $stable(mode));

endmodule

// File: rtl/jbr_bridge.sv
module jbr_bridge
  import jbr_pkg::*;
#(
  parameter int                MODE_W   = 8,
  parameter logic [MODE_W-1:0] MODE_RST = 1
) (
  input  logic              tck_i,
  input  logic              tms_i,
  input  logic              tdi_i,
  input  logic              trst_n_i,
  input  logic [ADDR_W-1:0] slot_addr_i,
  output logic              tdo_o,
  output logic              tdo_oe_o,
  output logic [3:0]        tap_state_o,
  output logic              selected_o,
  output logic              bcast_o,
  output logic [2:0]        cmd_o,
  output logic [MODE_W-1:0] mode_o
);

  logic    rst_meta, rst_n;
  tap_st_e state;
  logic    ir_lsb, dr_lsb;
  logic    sel_own, sel_bcast;
  cmd_e    cmd;
  logic    in_shift, tdo_d, oe_d;

  // asynchronous assertion, release aligned to TCK
  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  jbr_tap_ctrl u_tap (
    .tck   (tck_i),
    .rst_n (rst_n),
    .tms   (tms_i),
    .state (state)
  );

  jbr_ir_select u_ir (
    .tck       (tck_i),
    .rst_n     (rst_n),
    .state     (state),
    .tdi       (tdi_i),
    .slot_addr (slot_addr_i),
    .ir_lsb    (ir_lsb),
    .sel_own   (sel_own),
    .sel_bcast (sel_bcast),
    .cmd       (cmd)
  );

  jbr_dr_path #(.MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_dr (
    .tck    (tck_i),
    .rst_n  (rst_n),
    .state  (state),
    .tdi    (tdi_i),
    .cmd    (cmd),
    .dr_lsb (dr_lsb),
    .mode   (mode_o)
  );

  assign in_shift = (state == ST_SHIFT_IR) || (state == ST_SHIFT_DR);
  assign tdo_d    = (state == ST_SHIFT_IR) ? ir_lsb : dr_lsb;
  assign oe_d     = in_shift && sel_own;

  always_ff @(negedge tck_i or negedge rst_n) begin
    if (!rst_n) begin
      tdo_o    <= 1'b1;
      tdo_oe_o <= 1'b0;
    end else begin
      tdo_oe_o <= oe_d;
      if (in_shift) tdo_o <= tdo_d;
    end
  end

  assign tap_state_o = state;
  assign selected_o  = sel_own || sel_bcast;
  assign bcast_o     = sel_bcast;
  assign cmd_o       = cmd;

  // R4: a broadcast-selected bridge never drives the shared line
  a_r4_bcast_quiet: assert property (@(posedge tck_i) disable iff (!rst_n)
    bcast_o |-> !tdo_oe_o);

  // R11: the driver is enabled only inside a shift state
  a_r11_oe_in_shift: assert property (@(posedge tck_i) disable iff (!rst_n)
    tdo_oe_o |-> (tap_state_o == ST_SHIFT_IR || tap_state_o == ST_SHIFT_DR));

  // R2: an unselected bridge leaves the line undriven
  a_r2_wait_no_drive: assert property (@(posedge tck_i) disable iff (!rst_n)
    (!selected_o && !$past(selected_o)) |-> !tdo_oe_o);

endmodule

// File: tb/jbr_bridge_bench.sv
`timescale 1ns/100ps
module jbr_bridge_bench;

  localparam int MODE_W = 8;

  logic tck = 1'b0;
  logic tms, tdi, trst_n;
  logic [5:0] slot;
  logic tdo, tdo_oe;
  logic [3:0] tap_st;
  logic sel, bc;
  logic [2:0] cmd;
  logic [MODE_W-1:0] mode;
  wire  bus_tdo = tdo_oe ? tdo : 1'b1;

  int total = 0;
  int bad   = 0;

  logic  exp_q[$];
  string tag_q[$];

  always #2.5 tck = ~tck;

  jbr_bridge u_jbr_bridge (
    .tck_i(tck), .tms_i(tms), .tdi_i(tdi), .trst_n_i(trst_n),
    .slot_addr_i(slot), .tdo_o(tdo), .tdo_oe_o(tdo_oe),
    .tap_state_o(tap_st), .selected_o(sel), .bcast_o(bc),
    .cmd_o(cmd), .mode_o(mode)
  );

  // monitor: compares the bus against the scoreboard after each falling edge
  always @(negedge tck) begin
    #2;
    while (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_tdo !== e) begin
        bad++;
        $display("FAIL %s: bus tdo actual=%b expected=%b", t, bus_tdo, e);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle, scan n bits, return to Run-Test/Idle (or stop in Exit1)
  task automatic scan(input bit is_ir, input logic [15:0] din, input int n,
                      input logic [15:0] exp, input string tag, input bit stop_exit1);
    tick(1, 0);
    if (is_ir) tick(1, 0);
    tick(0, 0);
    tick(0, 0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp[i]);
      tag_q.push_back(tag);
      tick(i == n - 1, din[i]);
    end
    if (!stop_exit1) begin
      tick(1, 0);
      tick(0, 0);
    end
  endtask

  task automatic do_reset();
    trst_n = 1'b0;
    tms = 1'b1;
    tdi = 1'b0;
    repeat (3) @(posedge tck);
    @(negedge tck);
    #1;
    trst_n = 1'b1;
    repeat (3) tick(1, 0);
    tick(0, 0);
  endtask

  initial begin
    #250000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    slot = 6'h2D;
    do_reset();
    check("R10 reset selected", sel, 0);
    check("R10 reset cmd", cmd, 0);
    check("R10 reset mode", mode, 8'h01);

    scan(1, 16'h0015, 8, 16'hFFFF, "R2 unselected IR scan", 0);
    check("R5 foreign address", sel, 0);

    scan(1, 16'h002D, 8, 16'hFFFF, "R2 selecting scan", 0);
    check("R3 own selected", sel, 1);
    check("R3 not broadcast", bc, 0);

    scan(1, 16'h008E, 8, 16'h00B5, "R1 captured IR", 0);
    check("R6 MODESEL", cmd, 1);

    scan(0, 16'h00A6, 8, 16'h0001, "R8 mode capture", 0);
    check("R8 mode written", mode, 8'hA6);

    scan(1, 16'h0077, 8, 16'h00B5, "R1 captured IR", 0);
    check("R6 undefined gives BYPASS", cmd, 0);

    scan(0, 16'h000B, 4, 16'h0006, "R7 bypass delay", 0);
    check("R8 mode kept outside MODESEL", mode, 8'hA6);

    scan(1, 16'h00E2, 8, 16'h00B5, "R1 captured IR", 0);
    check("R6 UNPARK", cmd, 2);
    scan(1, 16'h00E3, 8, 16'h00B5, "R1 captured IR", 0);
    check("R6 PARKPAUSE", cmd, 3);
    scan(1, 16'h00FF, 8, 16'h00B5, "R1 captured IR", 0);
    check("R6 BYPASS", cmd, 0);

    // R11: bit changes on the falling edge only
    tick(1, 0);
    tick(0, 0);
    tick(0, 1);
    check("R11 oe in Shift-DR", tdo_oe, 1);
    check("R7 bypass capture 0", bus_tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck);
    #1;
    check("R11 steady after rising edge", bus_tdo, 0);
    @(negedge tck);
    #1;
    check("R11 new bit after falling edge", bus_tdo, 1);
    tick(1, 0);
    check("R11 oe off in Exit1-DR", tdo_oe, 0);
    tick(1, 0);
    tick(0, 0);

    scan(1, 16'h00C3, 8, 16'h00B5, "R1 captured IR", 0);
    check("R9 deselected", sel, 0);
    check("R9 cmd bypass", cmd, 0);
    check("R9 mode kept", mode, 8'hA6);
    scan(0, 16'h0005, 4, 16'hFFFF, "R2 unselected DR scan", 0);

    // broadcast
    scan(1, 16'h00C0, 8, 16'hFFFF, "R2 broadcast select scan", 0);
    check("R4 broadcast selected", sel, 1);
    check("R4 broadcast flag", bc, 1);
    scan(1, 16'h00E2, 8, 16'hFFFF, "R4 broadcast silent", 0);
    check("R6 UNPARK under broadcast", cmd, 2);
    scan(1, 16'h00C3, 8, 16'hFFFF, "R4 broadcast silent", 0);
    check("R9 broadcast deselected", sel, 0);
    check("R9 broadcast flag cleared", bc, 0);

    // R10: five TMS-high clocks
    scan(1, 16'h002D, 8, 16'hFFFF, "R2 selecting scan", 0);
    scan(1, 16'h008E, 8, 16'h00B5, "R1 captured IR", 0);
    scan(0, 16'h005C, 8, 16'h00A6, "R8 mode capture", 0);
    check("R8 mode written again", mode, 8'h5C);
    repeat (5) tick(1, 0);
    check("R10 tms reset state", tap_st, 4'hF);
    check("R10 tms reset deselects", sel, 0);
    check("R10 tms reset mode", mode, 8'h01);
    tick(0, 0);

    // same-cycle: test reset against Update-DR mode write
    scan(1, 16'h002D, 8, 16'hFFFF, "R2 selecting scan", 0);
    scan(1, 16'h008E, 8, 16'h00B5, "R1 captured IR", 0);
    scan(0, 16'h003C, 8, 16'h0001, "R8 mode capture", 1);
    tms = 1;
    trst_n = 0;
    @(posedge tck);
    @(negedge tck);
    #1;
    check("R10 trst beats mode write", mode, 8'h01);
    check("R10 trst deselects", sel, 0);
    check("R10 trst cmd", cmd, 0);
    trst_n = 1;
    repeat (3) tick(1, 0);
    tick(0, 0);
    scan(1, 16'h002D, 8, 16'hFFFF, "R2 after trst", 0);
    check("R3 reselect after trst", sel, 1);

    #20;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule